// File: doc/BRIEF.md
# Microcontroller Run-Control Unit

This unit is the host-facing control and status logic that sits beside an embedded microcontroller core. Through a small 32-bit register bus the host can hard-reset the core, load a boot address, clear a require-context flag, and launch the core. It can also observe whether the core is halted, whether the local memories have finished zero-filling, and whether the core or its external agents are busy. Fetch and execution are not modelled. The core appears only as a halt-request input and two busy inputs, and the block drives a run level, a one-cycle start pulse and the boot address.

After power-on reset, and after any host hard reset, two scrub counters walk the data memory and the instruction memory. Each takes a parameterised number of cycles. The core can be launched only once both scrubs are complete.

The run-control state machine has three states. SCRUB is entered on reset or on hard reset. In SCRUB, when both scrubs are done, the SCRUB_DONE transition goes to HALTED, or the SCRUB_LAUNCH transition goes straight to RUN if a start write arrives in that same cycle. From HALTED, the LAUNCH transition goes to RUN on a start write. From RUN, the HALT transition goes back to HALTED when the halt request is seen. From any state, the HARD_RESET transition goes to SCRUB and takes priority over every other transition.

Top module: `mcu_runctl`

## Requirements
- R1: Once rst_n is released, the control register (0x0) reads 0x10, so only bit 4 (halted) is set. The boot-vector register (0x4) reads 0. The DMA register (0x8) reads 0x7: bit 0 is require-context, bit 1 is the data-memory scrub flag and bit 2 is the instruction-memory scrub flag. core_need_ctx_o is 1 and core_run_o is 0.
- R2: After rst_n is released, or after a hard-reset write, DMA bit 1 reads 1 for exactly DMEM_SCRUB_CYC clock edges and DMA bit 2 reads 1 for exactly IMEM_SCRUB_CYC clock edges. Each bit then reads 0.
- R3: A write to 0x0 with bit 0 set is a hard reset. From the next cycle, core_run_o is 0, the halted bit reads 1, the boot vector reads 0, require-context reads 1 and both scrub flags read 1. A start bit (bit 1) in the same write is ignored.
- R4: A write to 0x0 with bit 1 set, made while the core is not running and both scrub flags read 0, launches the core. In the next cycle core_run_o is 1 and core_start_o pulses high for exactly one cycle. Bit 4 then reads 0. Bits 0 and 1 of 0x0 always read 0.
- R5: A start write made while a scrub flag reads 1, or while the core is running, produces no start pulse and leaves the run state unchanged.
- R6: halt_req_i high while the core is running makes core_run_o 0 and bit 4 read 1 from the next cycle. While the core is halted, halt_req_i has no effect, so a start write in the same cycle still launches the core.
- R7: The boot-vector register at 0x4 is read/write over its full width and drives core_boot_addr_o.
- R8: Bit 0 of 0x8 is read/write and drives core_need_ctx_o. Bits 1 and 2 of 0x8 are read-only.
- R9: The idle register at 0xC reads busy_int_i in bit 0, busy_ext_i in bit 1, and in bit 2 a 1 only when both busy inputs are 0. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register byte address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i (combinational) |
| halt_req_i | input | 1 | Halt request from the core |
| busy_int_i | input | 1 | Core internal busy |
| busy_ext_i | input | 1 | External busy |
| core_run_o | output | 1 | Core is running |
| core_start_o | output | 1 | One-cycle launch pulse |
| core_boot_addr_o | output | DATA_W | Boot address |
| core_need_ctx_o | output | 1 | Require-context flag |

## Verification
Three pairs of events can land on the same clock edge, and each pair has a defined winner:
- A hard reset and a start arriving in one write: hard reset wins.
- A halt request and a start write while the core is halted: the start wins.
- A start write and the scrub completion: the launch goes through only when both scrub flags already read 0.

The bench drives each pair on the same edge. It judges the outcome from the halted bit, the run level and the start pulse in the following cycle. It also times the scrub flags edge by edge after both power-on and a hard reset.

// File: rtl/runctl_pkg.sv
package runctl_pkg;
    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_BOOT = 4'h4;
    localparam logic [3:0] A_DMA  = 4'h8;
    localparam logic [3:0] A_IDLE = 4'hC;

    localparam int B_HRST   = 0;
    localparam int B_START  = 1;
    localparam int B_HALTED = 4;
    localparam int B_CTX    = 0;
    localparam int B_DSCRUB = 1;
    localparam int B_ISCRUB = 2;
    localparam int B_IBUSY  = 0;
    localparam int B_EBUSY  = 1;
    localparam int B_IDLE   = 2;

    typedef enum logic [1:0] {
        ST_SCRUB  = 2'd0,
        ST_HALTED = 2'd1,
        ST_RUN    = 2'd2
    } run_state_t;
endpackage

// File: rtl/runctl_scrubber.sv
module runctl_scrubber #(
    parameter int CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic busy
);
    localparam int CNT_W = $clog2(CYC + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYC);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= LOAD;
        end else if (restart) begin
            cnt_q <= LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/runctl_fsm.sv
module runctl_fsm
    import runctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hrst_req,
    input  logic start_req,
    input  logic halt_req,
    input  logic scrub_busy,
    output logic run_o,
    output logic start_o
);
    run_state_t st_q, st_d;
    logic       start_ok;

    assign start_ok = start_req && !hrst_req && !scrub_busy && (st_q != ST_RUN);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_SCRUB: begin
                if (!scrub_busy) begin
                    st_d = start_ok ? ST_RUN : ST_HALTED;
                end
            end
            ST_HALTED: begin
                if (start_ok) begin
                    st_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (halt_req) begin
                    st_d = ST_HALTED;
                end
            end
            default: st_d = ST_SCRUB;
        endcase
        if (hrst_req) begin
            st_d = ST_SCRUB;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_SCRUB;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_o   <= 1'b0;
            start_o <= 1'b0;
        end else begin
            run_o   <= (st_d == ST_RUN);
            start_o <= start_ok;
        end
    end
endmodule

// File: rtl/runctl_regs.sv
module runctl_regs
    import runctl_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              hrst_req,
    input  logic              halted,
    input  logic [1:0]        scrub_busy,
    input  logic              busy_int,
    input  logic              busy_ext,
    output logic [DATA_W-1:0] boot_vec,
    output logic              need_ctx,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(A_CTRL);
    localparam logic [ADDR_W-1:0] AD_BOOT = ADDR_W'(A_BOOT);
    localparam logic [ADDR_W-1:0] AD_DMA  = ADDR_W'(A_DMA);
    localparam logic [ADDR_W-1:0] AD_IDLE = ADDR_W'(A_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            boot_vec <= '0;
            need_ctx <= 1'b1;
        end else if (hrst_req) begin
            boot_vec <= '0;
            need_ctx <= 1'b1;
        end else if (we) begin
            if (addr == AD_BOOT) boot_vec <= wdata;
            if (addr == AD_DMA)  need_ctx <= wdata[B_CTX];
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            AD_CTRL: rdata[B_HALTED] = halted;
            AD_BOOT: rdata = boot_vec;
            AD_DMA: begin
                rdata[B_CTX]    = need_ctx;
                rdata[B_DSCRUB] = scrub_busy[0];
                rdata[B_ISCRUB] = scrub_busy[1];
            end
            AD_IDLE: begin
                rdata[B_IBUSY] = busy_int;
                rdata[B_EBUSY] = busy_ext;
                rdata[B_IDLE]  = !busy_int && !busy_ext;
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/mcu_runctl.sv
module mcu_runctl
    import runctl_pkg::*;
#(
    parameter int ADDR_W         = 4,
    parameter int DATA_W         = 32,
    parameter int DMEM_SCRUB_CYC = 16,
    parameter int IMEM_SCRUB_CYC = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              halt_req_i,
    input  logic              busy_int_i,
    input  logic              busy_ext_i,
    output logic              core_run_o,
    output logic              core_start_o,
    output logic [DATA_W-1:0] core_boot_addr_o,
    output logic              core_need_ctx_o
);
    localparam int NMEM = 2;

    logic            ctrl_wr;
    logic            hrst_req;
    logic            start_req;
    logic [NMEM-1:0] scrub_busy;

    assign ctrl_wr   = bus_we_i && (bus_addr_i == ADDR_W'(A_CTRL));
    assign hrst_req  = ctrl_wr && bus_wdata_i[B_HRST];
    assign start_req = ctrl_wr && bus_wdata_i[B_START];

    for (genvar g = 0; g < NMEM; g++) begin : g_scrub
        localparam int CYC = (g == 0) ? DMEM_SCRUB_CYC : IMEM_SCRUB_CYC;
        runctl_scrubber #(.CYC(CYC)) u_scrub (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (hrst_req),
            .busy    (scrub_busy[g])
        );
    end

    runctl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hrst_req   (hrst_req),
        .start_req  (start_req),
        .halt_req   (halt_req_i),
        .scrub_busy (|scrub_busy),
        .run_o      (core_run_o),
        .start_o    (core_start_o)
    );

    runctl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (bus_we_i),
        .addr       (bus_addr_i),
        .wdata      (bus_wdata_i),
        .hrst_req   (hrst_req),
        .halted     (!core_run_o),
        .scrub_busy (scrub_busy),
        .busy_int   (busy_int_i),
        .busy_ext   (busy_ext_i),
        .boot_vec   (core_boot_addr_o),
        .need_ctx   (core_need_ctx_o),
        .rdata      (bus_rdata_o)
    );
endmodule

// File: rtl/mcu_runctl_chk.sv
module mcu_runctl_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [DATA_W-1:0] bus_wdata_i,
    input logic              halt_req_i,
    input logic              core_run_o,
    input logic              core_start_o,
    input logic [DATA_W-1:0] core_boot_addr_o,
    input logic [1:0]        scrub_busy
);
    logic hrst_wr;
    assign hrst_wr = bus_we_i && (bus_addr_i == '0) && bus_wdata_i[0];

    // R4
    start_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_start_o |-> core_run_o);

    // R4
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_start_o |=> !core_start_o);

    // R3
    hard_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hrst_wr |=> (!core_run_o && core_boot_addr_o == '0 && !core_start_o));

    // R2
    scrub_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hrst_wr |=> (scrub_busy == 2'b11));

    // R5
    run_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_run_o |-> (scrub_busy == 2'b00));

    // R6
    halt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_run_o && halt_req_i) |=> !core_run_o);
endmodule

bind mcu_runctl mcu_runctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .bus_we_i         (bus_we_i),
    .bus_addr_i       (bus_addr_i),
    .bus_wdata_i      (bus_wdata_i),
    .halt_req_i       (halt_req_i),
    .core_run_o       (core_run_o),
    .core_start_o     (core_start_o),
    .core_boot_addr_o (core_boot_addr_o),
    .scrub_busy       (scrub_busy)
);

// File: tb/mcu_runctl_test.sv
module mcu_runctl_test;
    localparam int CLK_PERIOD = 10;
    localparam int DCYC = 16;
    localparam int ICYC = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we_i = 1'b0;
    logic [3:0]  bus_addr_i = '0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        halt_req_i = 1'b0;
    logic        busy_int_i = 1'b0;
    logic        busy_ext_i = 1'b0;
    logic        core_run_o, core_start_o, core_need_ctx_o;
    logic [31:0] core_boot_addr_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcu_runctl #(.DMEM_SCRUB_CYC(DCYC), .IMEM_SCRUB_CYC(ICYC)) uut (
        .clk(clk), .rst_n(rst_n), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .halt_req_i(halt_req_i),
        .busy_int_i(busy_int_i), .busy_ext_i(busy_ext_i), .core_run_o(core_run_o),
        .core_start_o(core_start_o), .core_boot_addr_o(core_boot_addr_o),
        .core_need_ctx_o(core_need_ctx_o)
    );

    typedef struct packed {
        logic        we;
        logic [3:0]  addr;
        logic [31:0] wd;
        logic        halt;
        logic        bi;
        logic        be;
        logic [3:0]  ra;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'h4, 32'h0000_0100, 1'b0, 1'b0, 1'b0, 4'h4, 32'h100, 8'd7}, // R7
        '{1'b0, 4'h0, 32'h0,         1'b0, 1'b1, 1'b0, 4'hC, 32'h1,   8'd9}, // R9
        '{1'b0, 4'h0, 32'h0,         1'b0, 1'b0, 1'b1, 4'hC, 32'h2,   8'd9}, // R9
        '{1'b0, 4'h0, 32'h0,         1'b0, 1'b0, 1'b0, 4'hC, 32'h4,   8'd9}, // R9
        '{1'b1, 4'h8, 32'h0,         1'b0, 1'b0, 1'b0, 4'h8, 32'h0,   8'd8}, // R8
        '{1'b1, 4'h0, 32'h2,         1'b0, 1'b0, 1'b0, 4'h0, 32'h0,   8'd4}, // R4
        '{1'b0, 4'h0, 32'h0,         1'b1, 1'b0, 1'b0, 4'h0, 32'h10,  8'd6}, // R6
        '{1'b1, 4'h0, 32'h2,         1'b0, 1'b0, 1'b0, 4'h0, 32'h0,   8'd4}, // R4
        '{1'b1, 4'h0, 32'h3,         1'b0, 1'b0, 1'b0, 4'h0, 32'h10,  8'd3}, // R3
        '{1'b0, 4'h0, 32'h0,         1'b0, 1'b0, 1'b0, 4'h8, 32'h7,   8'd3}, // R3
        '{1'b0, 4'h0, 32'h0,         1'b0, 1'b0, 1'b0, 4'h4, 32'h0,   8'd3}, // R3
        '{1'b0, 4'h0, 32'h0,         1'b0, 1'b0, 1'b0, 4'h6, 32'h0,   8'd9}  // R9
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_we_i = 1'b0;
        bus_addr_i = a;
        #1;
        d = bus_rdata_o;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_we_i = 1'b1;
        bus_addr_i = a;
        bus_wdata_i = d;
        tick();
        bus_we_i = 1'b0;
    endtask

    task automatic scrub_time(input string req);
        int dk = 0;
        int ik = 0;
        logic [31:0] d;
        for (int k = 1; k <= 100; k++) begin
            tick();
            rd(4'h8, d);
            if (!d[1] && dk == 0) dk = k;
            if (!d[2] && ik == 0) ik = k;
            if (dk != 0 && ik != 0) break;
        end
        check({req, " dmem scrub"}, 32'(dk), 32'(DCYC));
        check({req, " imem scrub"}, 32'(ik), 32'(ICYC));
    endtask

    initial begin
        int wd = 0;
        while (wd < 20000) begin
            @(posedge clk);
            wd++;
        end
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(4'h0, d); check("R1 ctrl", d, 32'h10);
        rd(4'h4, d); check("R1 boot", d, 32'h0);
        rd(4'h8, d); check("R1 dma", d, 32'h7);
        check("R1 need_ctx", 32'(core_need_ctx_o), 32'h1);
        check("R1 run", 32'(core_run_o), 32'h0);
        // R2 after power-on
        scrub_time("R2 por");

        for (int i = 0; i < NV; i++) begin
            bus_we_i = VEC[i].we;
            bus_addr_i = VEC[i].addr;
            bus_wdata_i = VEC[i].wd;
            halt_req_i = VEC[i].halt;
            busy_int_i = VEC[i].bi;
            busy_ext_i = VEC[i].be;
            tick();
            halt_req_i = 1'b0;
            rd(VEC[i].ra, d);
            check($sformatf("R%0d vector %0d", VEC[i].req, i), d, VEC[i].exp);
            if (i == 0) check("R7 boot out", core_boot_addr_o, 32'h100);
            if (i == 4) check("R8 need_ctx out", 32'(core_need_ctx_o), 32'h0);
            if (i == 5) check("R4 pulse", 32'(core_start_o), 32'h1);
            if (i == 8) check("R3 run low", 32'(core_run_o), 32'h0);
        end

        // R5 start during scrub is ignored
        wr(4'h0, 32'h2);
        check("R5 no pulse in scrub", 32'(core_start_o), 32'h0);
        check("R5 no run in scrub", 32'(core_run_o), 32'h0);
        repeat (30) tick();
        rd(4'h0, d); check("R5 still halted", d, 32'h10);

        // R2 after hard reset
        wr(4'h0, 32'h11);
        scrub_time("R2 hrst");
        tick();

        // R6 halt and start together while halted: start wins
        halt_req_i = 1'b1;
        wr(4'h0, 32'h2);
        halt_req_i = 1'b0;
        check("R6 start wins run", 32'(core_run_o), 32'h1);
        rd(4'h0, d); check("R6 start wins halted", d, 32'h0);
        tick();
        check("R4 pulse ends", 32'(core_start_o), 32'h0);

        // R5 start while running gives no pulse
        wr(4'h0, 32'h2);
        check("R5 no pulse in run", 32'(core_start_o), 32'h0);
        check("R5 still run", 32'(core_run_o), 32'h1);

        // R6 halt while running
        halt_req_i = 1'b1;
        tick();
        halt_req_i = 1'b0;
        check("R6 halt stops", 32'(core_run_o), 32'h0);

        // R7 boot vector full width
        wr(4'h4, 32'hA5C3_0F81);
        rd(4'h4, d); check("R7 boot rw", d, 32'hA5C3_0F81);
        check("R7 boot out", core_boot_addr_o, 32'hA5C3_0F81);

        // R8 scrub flags read-only
        wr(4'h8, 32'h6);
        rd(4'h8, d); check("R8 ro flags", d, 32'h0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule